// File: doc/BRIEF.md
# Converter Configuration SPI Register Slave

This block is the serial configuration port of a high-speed data converter. An external host reaches it over a four-wire SPI link in mode 0 (clock idles low). Each access is a fixed 24-bit frame. A 16-bit instruction comes first: a direction flag in its top bit and a 15-bit register address below it. One data byte follows. The SPI pins are oversampled by the system clock through two-flop synchronisers, so the serial clock has to be several system clocks slower than the system clock.

Configuration writes never reach the converter datapath directly. They land in a staging copy of each register. A single commit write then moves every staged value into the live copies in one system clock cycle. The live copies drive the datapath controls: test pattern selector, output number format, data-clock inversion, even/odd output mode, output clock delay and reference selection. Reads always report the live copy, so the host sees what the datapath is using at that moment.

Top module: `cfg_spi_regs`

## Requirements
- R1: A frame is 24 bits, shifted in MSB first on rising serial clock edges while chip select is low. Frame bit 23 is 1 for a read and 0 for a write. Bits 22:16 are address bits 14:8. Bits 15:8 are address bits 7:0. Bits 7:0 are the data byte.
- R2: During a read, the data byte is driven on the MISO pin MSB first. Each bit changes after a falling serial clock edge, starting with the falling edge that follows the 16th rising edge.
- R3: A write to address 0x0D, 0x14, 0x16, 0x17 or 0x18 changes only the staged copy. The live outputs, and the value read back from that address, stay unchanged until a commit.
- R4: Writing 0x01 to address 0x00FF copies every staged register into its live register in the same cycle. Any other data value written to 0x00FF has no effect.
- R5: Address 0x0001 reads as the constant 0x50, and writes to it are ignored.
- R6: Addresses other than 0x0001, 0x000D, 0x0014, 0x0016, 0x0017 and 0x0018 read as 0x00, and writes to them change nothing. This includes 0x00FF and any address with a nonzero upper byte.
- R7: Address 0x18 keeps only bits 3:0 as the reference code. A written code that is not one of 0, 6, 7, 8, 9 or 10 is discarded, and the staged value is left as it was.
- R8: Stored fields are as follows. 0x0D keeps bits 3:0 as the test selector. 0x14 keeps all 8 bits, and bits 1:0 select the format (0 offset binary, 1 two's complement, 2 Gray). 0x16 keeps bit 7 (data-clock invert) and bit 5 (even/odd mode). 0x17 keeps bit 7 (clock delay enable). All other bits read as 0.
- R9: If chip select rises before the 24th rising serial clock edge, the frame is dropped and no register changes.
- R10: Reset clears every staged and live register to zero, which puts the format at offset binary. MISO is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSclk | input | 1 | Serial clock from host, idle low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial read data to host |
| testModeSel | output | 4 | Live test pattern selector |
| outModeCfg | output | 8 | Live output mode byte |
| numFormat | output | 2 | Live number format code |
| dataClkInvert | output | 1 | Live data-clock inversion |
| evenOddEn | output | 1 | Live even/odd output enable |
| clkDelayEn | output | 1 | Live output clock delay enable |
| refSelect | output | 4 | Live reference select code |

## Verification
If a live register is updated too early, a staged value shows up on the datapath outputs and on readback before the commit. The per-clock comparison against the bench model catches this a few system clocks after the 24th serial edge of the staging write. If a staged register holds a wrong value, nothing is visible until the next commit. Right after that commit, the outputs and a readback both show the wrong field. Errors in bit counting or abort handling show up as a wrong MISO bit within the same read frame, or as an output change after a dropped frame.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 15;
  localparam int INSTR_BITS = ADDR_W + 1;
  localparam int FRAME_BITS = INSTR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int NREG       = 5;

  localparam logic [ADDR_W-1:0] ID_ADDR     = 15'h0001;
  localparam logic [DATA_W-1:0] ID_VALUE    = 8'h50;
  localparam logic [ADDR_W-1:0] COMMIT_ADDR = 15'h00FF;
  localparam logic [DATA_W-1:0] COMMIT_VAL  = 8'h01;

  // Register slots inside the register file
  localparam int TEST_IDX  = 0;
  localparam int MODE_IDX  = 1;
  localparam int PHASE_IDX = 2;
  localparam int DELAY_IDX = 3;
  localparam int REF_IDX   = 4;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } regStb_t;

  function automatic logic [ADDR_W-1:0] slotAddr(input int idx);
    case (idx)
      TEST_IDX:  return 15'h000D;
      MODE_IDX:  return 15'h0014;
      PHASE_IDX: return 15'h0016;
      DELAY_IDX: return 15'h0017;
      default:   return 15'h0018;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slotMask(input int idx);
    case (idx)
      TEST_IDX:  return 8'h0F;
      MODE_IDX:  return 8'hFF;
      PHASE_IDX: return 8'hA0;
      DELAY_IDX: return 8'h80;
      default:   return 8'h0F;
    endcase
  endfunction

  function automatic logic refCodeOk(input logic [3:0] code);
    return (code == 4'd0) || ((code >= 4'd6) && (code <= 4'd10));
  endfunction

endpackage

// File: rtl/cfgspi_ctrl.sv
module cfgspi_ctrl
  import cfgspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output regStb_t           stb,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData
);

  localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_BITS - 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(INSTR_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_BITS);

  logic [1:0] csS;
  logic [2:0] sclkS;
  logic [1:0] mosiS;

  logic csLow, sclkRise, sclkFall, mosiBit;

  logic [CNT_W-1:0]      bitCnt;
  logic [INSTR_BITS-2:0] shiftIn;
  logic                  rnwQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     txShift;
  logic                  txLoadPend;
  logic                  misoQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csS   <= '1;
      sclkS <= '0;
      mosiS <= '0;
    end else begin
      csS   <= {csS[0], spiCsN};
      sclkS <= {sclkS[1:0], spiSclk};
      mosiS <= {mosiS[0], spiMosi};
    end
  end

  assign csLow    = !csS[1];
  assign sclkRise = sclkS[1] && !sclkS[2];
  assign sclkFall = !sclkS[1] && sclkS[2];
  assign mosiBit  = mosiS[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt     <= '0;
      shiftIn    <= '0;
      rnwQ       <= 1'b0;
      addrQ      <= '0;
      txShift    <= '0;
      txLoadPend <= 1'b0;
      misoQ      <= 1'b0;
      stb        <= '0;
    end else begin
      stb.wrEn <= 1'b0;
      if (!csLow) begin
        bitCnt     <= '0;
        txLoadPend <= 1'b0;
        misoQ      <= 1'b0;
      end else begin
        if (sclkRise && (bitCnt < FRAME_END)) begin
          shiftIn <= {shiftIn[INSTR_BITS-3:0], mosiBit};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == LAST_INSTR) begin
            rnwQ       <= shiftIn[INSTR_BITS-2];
            addrQ      <= {shiftIn[ADDR_W-2:0], mosiBit};
            txLoadPend <= shiftIn[INSTR_BITS-2];
          end
          if ((bitCnt == LAST_BIT) && !rnwQ) begin
            stb.wrEn <= 1'b1;
            stb.addr <= addrQ;
            stb.data <= {shiftIn[DATA_W-2:0], mosiBit};
          end
        end
        if (txLoadPend) begin
          txShift    <= rdData;
          txLoadPend <= 1'b0;
        end
        if (sclkFall) begin
          if (rnwQ && (bitCnt >= FIRST_DATA) && (bitCnt < FRAME_END)) begin
            misoQ   <= txShift[DATA_W-1];
            txShift <= {txShift[DATA_W-2:0], 1'b0};
          end else begin
            misoQ <= 1'b0;
          end
        end
      end
    end
  end

  assign rdAddr  = addrQ;
  assign spiMiso = misoQ;

  // R10
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csLow |=> !spiMiso);

  // R9
  wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> $past(csLow));

  // R1
  bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FRAME_END);

  // R1
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> !stb.wrEn);

endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
  import cfgspi_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  regStb_t                      stb,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [DATA_W-1:0]            rdData,
  output logic [NREG-1:0][DATA_W-1:0]  liveCfg
);

  logic [NREG-1:0][DATA_W-1:0] shadowQ;
  logic [NREG-1:0][DATA_W-1:0] liveQ;
  logic [NREG-1:0]             stageHit;
  logic                        commitHit;

  assign commitHit = stb.wrEn && (stb.addr == COMMIT_ADDR) && (stb.data == COMMIT_VAL);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i == REF_IDX) begin : g_ref
      assign stageHit[i] = stb.wrEn && (stb.addr == slotAddr(i)) && refCodeOk(stb.data[3:0]);
    end else begin : g_plain
      assign stageHit[i] = stb.wrEn && (stb.addr == slotAddr(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      liveQ   <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (stageHit[i]) shadowQ[i] <= stb.data & slotMask(i);
      end
      if (commitHit) liveQ <= shadowQ;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ID_ADDR) rdData = ID_VALUE;
    for (int i = 0; i < NREG; i++) begin
      if (rdAddr == slotAddr(i)) rdData = liveQ[i];
    end
  end

  assign liveCfg = liveQ;

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitHit |=> (liveQ == $past(shadowQ)));

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitHit |=> $stable(liveQ));

  // R7
  ref_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    refCodeOk(shadowQ[REF_IDX][3:0]) && refCodeOk(liveQ[REF_IDX][3:0]));

  // R8
  phase_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveQ[PHASE_IDX] & 8'h5F) == 8'h00);

endmodule

// File: rtl/cfg_spi_regs.sv
module cfg_spi_regs
  import cfgspi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiMosi,
  output logic       spiMiso,
  output logic [3:0] testModeSel,
  output logic [7:0] outModeCfg,
  output logic [1:0] numFormat,
  output logic       dataClkInvert,
  output logic       evenOddEn,
  output logic       clkDelayEn,
  output logic [3:0] refSelect
);

  regStb_t                     stb;
  logic [ADDR_W-1:0]           rdAddr;
  logic [DATA_W-1:0]           rdData;
  logic [NREG-1:0][DATA_W-1:0] liveCfg;

  cfgspi_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .spiSclk (spiSclk),
    .spiCsN  (spiCsN),
    .spiMosi (spiMosi),
    .spiMiso (spiMiso),
    .stb     (stb),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );

  cfgspi_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .liveCfg (liveCfg)
  );

  assign testModeSel   = liveCfg[TEST_IDX][3:0];
  assign outModeCfg    = liveCfg[MODE_IDX];
  assign numFormat     = liveCfg[MODE_IDX][1:0];
  assign dataClkInvert = liveCfg[PHASE_IDX][7];
  assign evenOddEn     = liveCfg[PHASE_IDX][5];
  assign clkDelayEn    = liveCfg[DELAY_IDX][7];
  assign refSelect     = liveCfg[REF_IDX][3:0];

endmodule

// File: tb/tb_cfg_spi_regs.sv
module tb_cfg_spi_regs;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0;
  logic spiCsN = 1'b1;
  logic spiMosi = 1'b0;
  logic spiMiso;
  logic [3:0] testModeSel;
  logic [7:0] outModeCfg;
  logic [1:0] numFormat;
  logic dataClkInvert, evenOddEn, clkDelayEn;
  logic [3:0] refSelect;

  int checks = 0;
  int failures = 0;
  bit busy = 1'b1;
  bit finished = 1'b0;

  // behavioural model: slots 0..4 = 0x0D, 0x14, 0x16, 0x17, 0x18
  logic [7:0] shadowM [5];
  logic [7:0] liveM [5];

  always #5 clk = ~clk;

  cfg_spi_regs dut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .testModeSel(testModeSel), .outModeCfg(outModeCfg),
    .numFormat(numFormat), .dataClkInvert(dataClkInvert), .evenOddEn(evenOddEn),
    .clkDelayEn(clkDelayEn), .refSelect(refSelect)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int slotOf(input logic [14:0] a);
    case (a)
      15'h000D: return 0;
      15'h0014: return 1;
      15'h0016: return 2;
      15'h0017: return 3;
      15'h0018: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [7:0] maskOf(input int s);
    case (s)
      0: return 8'h0F;
      1: return 8'hFF;
      2: return 8'hA0;
      3: return 8'h80;
      default: return 8'h0F;
    endcase
  endfunction

  function automatic logic [7:0] modelRead(input logic [14:0] a);
    int s;
    if (a == 15'h0001) return 8'h50;
    s = slotOf(a);
    if (s >= 0) return liveM[s];
    return 8'h00;
  endfunction

  task automatic modelWrite(input logic [14:0] a, input logic [7:0] d);
    int s;
    if (a == 15'h00FF) begin
      if (d == 8'h01) for (int i = 0; i < 5; i++) liveM[i] = shadowM[i];
      return;
    end
    s = slotOf(a);
    if (s < 0) return;
    if (s == 4 && !((d[3:0] == 4'd0) || (d[3:0] >= 4'd6 && d[3:0] <= 4'd10))) return;
    shadowM[s] = d & maskOf(s);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit rnw, input logic [14:0] a, input logic [7:0] d,
                      input int stopAfter, output logic [7:0] rd);
    logic [23:0] frame;
    frame = {rnw, a, d};
    rd = '0;
    busy = 1'b1;
    spiCsN = 1'b0;
    waitClk(HALF);
    for (int b = 0; b < 24; b++) begin
      if (b >= stopAfter) break;
      spiMosi = frame[23-b];
      waitClk(HALF);
      if (b >= 16) rd[23-b] = spiMiso;
      spiSclk = 1'b1;
      waitClk(HALF);
      spiSclk = 1'b0;
    end
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(8);
    if (stopAfter >= 24 && !rnw) modelWrite(a, d);
    busy = 1'b0;
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer(1'b0, a, d, 24, dummy);
  endtask

  task automatic rdChk(input logic [14:0] a, input string tag);
    logic [7:0] got;
    logic [7:0] exp;
    exp = modelRead(a);
    xfer(1'b1, a, 8'h00, 24, got);
    chk(got == exp, tag, got, exp);
  endtask

  // per-clock comparison of live outputs against the model (R3, R4, R8)
  always @(negedge clk) begin
    if (rstN && !busy && !finished) begin
      chk(testModeSel == liveM[0][3:0], "R3 testModeSel", testModeSel, liveM[0][3:0]);
      chk(outModeCfg == liveM[1], "R8 outModeCfg", outModeCfg, liveM[1]);
      chk(numFormat == liveM[1][1:0], "R8 numFormat", numFormat, liveM[1][1:0]);
      chk(dataClkInvert == liveM[2][7], "R8 dataClkInvert", dataClkInvert, liveM[2][7]);
      chk(evenOddEn == liveM[2][5], "R8 evenOddEn", evenOddEn, liveM[2][5]);
      chk(clkDelayEn == liveM[3][7], "R8 clkDelayEn", clkDelayEn, liveM[3][7]);
      chk(refSelect == liveM[4][3:0], "R4 refSelect", refSelect, liveM[4][3:0]);
      chk(spiMiso == 1'b0, "R10 miso idle", spiMiso, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    for (int i = 0; i < 5; i++) begin shadowM[i] = '0; liveM[i] = '0; end
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // R10 reset state
    chk(outModeCfg == 8'h00 && testModeSel == 4'h0 && refSelect == 4'h0,
        "R10 reset outputs", {outModeCfg, testModeSel, refSelect}, 0);
    chk(spiMiso == 1'b0, "R10 miso after reset", spiMiso, 0);
    busy = 1'b0;

    // R5 identifier read, R1/R2 framing
    rdChk(15'h0001, "R5 id read");
    // R3 staging only
    wr(15'h000D, 8'h35);
    rdChk(15'h000D, "R3 staged not visible");
    chk(testModeSel == 4'h0, "R3 output before commit", testModeSel, 0);
    // R4 commit
    wr(15'h00FF, 8'h01);
    chk(testModeSel == 4'h5, "R4 commit test mode", testModeSel, 5);
    rdChk(15'h000D, "R2 readback live test mode");
    // R8 fields
    wr(15'h0014, 8'h09);
    wr(15'h0016, 8'hFF);
    wr(15'h0017, 8'hFF);
    wr(15'h0018, 8'h07);
    wr(15'h00FF, 8'h01);
    chk(numFormat == 2'd1, "R8 two's complement format", numFormat, 1);
    chk(refSelect == 4'd7, "R7 ref code 7", refSelect, 7);
    rdChk(15'h0014, "R8 mode readback");
    rdChk(15'h0016, "R8 phase readback masked");
    rdChk(15'h0017, "R8 delay readback masked");
    rdChk(15'h0018, "R7 ref readback");
    // R7 invalid reference codes discarded
    wr(15'h0018, 8'h03);
    wr(15'h0018, 8'hFB);
    wr(15'h00FF, 8'h01);
    chk(refSelect == 4'd7, "R7 invalid ref ignored", refSelect, 7);
    wr(15'h0018, 8'h0A);
    wr(15'h00FF, 8'h01);
    chk(refSelect == 4'd10, "R7 ref code 10", refSelect, 10);
    // R4 non-commit value to transfer address
    wr(15'h000D, 8'h0F);
    wr(15'h00FF, 8'h02);
    chk(testModeSel == 4'h5, "R4 wrong commit value ignored", testModeSel, 5);
    wr(15'h00FF, 8'h01);
    chk(testModeSel == 4'hF, "R4 commit after ignored", testModeSel, 15);
    // R5 write to identifier ignored
    wr(15'h0001, 8'h12);
    rdChk(15'h0001, "R5 id after write");
    // R6 unimplemented addresses
    wr(15'h0040, 8'hAA);
    rdChk(15'h0040, "R6 unimplemented read");
    rdChk(15'h00FF, "R6 transfer address read");
    wr(15'h0114, 8'h02);
    wr(15'h00FF, 8'h01);
    chk(outModeCfg == 8'h09, "R6 upper address write ignored", outModeCfg, 9);
    rdChk(15'h0114, "R6 upper address read");
    // R9 aborted frames
    xfer(1'b0, 15'h000D, 8'h03, 20, junk);
    xfer(1'b0, 15'h00FF, 8'h01, 23, junk);
    chk(testModeSel == 4'hF, "R9 abort no change", testModeSel, 15);
    wr(15'h00FF, 8'h01);
    chk(testModeSel == 4'hF, "R9 aborted write not staged", testModeSel, 15);
    // R2 read pattern with alternating bits
    wr(15'h0014, 8'hA6);
    wr(15'h00FF, 8'h01);
    rdChk(15'h0014, "R2 alternating read pattern");
    chk(numFormat == 2'd2, "R8 Gray format", numFormat, 2);
    // R10 reset mid-state
    rstN = 1'b0;
    busy = 1'b1;
    waitClk(3);
    for (int i = 0; i < 5; i++) begin shadowM[i] = '0; liveM[i] = '0; end
    rstN = 1'b1;
    waitClk(2);
    busy = 1'b0;
    chk(outModeCfg == 8'h00 && refSelect == 4'h0, "R10 second reset", outModeCfg, 0);
    wr(15'h00FF, 8'h01);
    chk(testModeSel == 4'h0, "R10 staged cleared by reset", testModeSel, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule